// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between a synchronous request source and an external asynchronous static RAM that holds 512K bytes. Each accepted request is a single byte read or a single byte write. The block turns it into a timed sequence of active-low chip-enable, write-enable and output-enable strobes. It holds the address bus steady and drives a split data port: data out, a drive enable for the pad, and data in. For reads it returns the captured byte with a one-cycle valid pulse.

Every timing interval the memory needs is given as a parameter in nanoseconds, next to the system clock period. The block converts each one into a whole number of clock cycles, rounding up, with a minimum of one cycle. Writes are always controlled by write enable; chip enable frames the write.

After every read the bus is handed back with a float gap before anything else may start. The data driver is enabled only once write enable is already low. It is released one cycle after write enable rises.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is asserted, sram_ce_n, sram_we_n and sram_oe_n are 1, dq_oe and rd_valid are 0, and req_ready is 1.
- R2: Strobe encoding (0 = asserted). Idle and gaps use ce_n=1. A read uses ce_n=0, oe_n=0, we_n=1. A write uses ce_n=0, we_n=0, oe_n=1. oe_n is never 0 while we_n is 0 or dq_oe is 1, and we_n is never 0 while ce_n is 1.
- R3: During a read, sram_oe_n stays 0 for exactly ceil(T_AA_NS/CLK_NS) cycles. rd_data holds the byte present on dq_in at the end of that window. rd_valid is a single-cycle pulse.
- R4: During a write, sram_we_n stays 0 for at least ceil(T_WP_NS/CLK_NS) cycles.
- R5: dq_oe rises only while sram_we_n is 0, and only after we_n has been 0 for exactly ceil(T_WHZ_NS/CLK_NS) cycles. dq_oe stays 1 for at least ceil(T_DW_NS/CLK_NS) cycles before we_n rises. dq_oe is 1 in the first cycle after we_n rises and 0 in the cycle after that.
- R6: sram_addr does not change while sram_ce_n is 0. During a write, sram_ce_n is 0 for at least ceil(T_AS_NS/CLK_NS) cycles before sram_we_n falls.
- R7: After a read, sram_ce_n stays 1 for at least ceil(T_OHZ_NS/CLK_NS) cycles before the next access starts.
- R8: A request is taken on a clock edge where req_valid and req_ready are both 1. req_ready is 0 from the cycle after acceptance until the whole sequence and the cycle time (T_RC_NS for a read, T_WC_NS for a write) have elapsed. A request presented while req_ready is 0 has no effect.
- R9: Each interval count is max(1, ceil(ns / CLK_NS)). An interval of 0 ns therefore still costs one cycle.
- R10: dq_out holds the accepted write byte, unchanged while dq_oe is 1. A later read of the same address returns that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Byte to write |
| rd_valid | output | 1 | One-cycle pulse, rd_data is valid |
| rd_data | output | DATA_W | Byte read from memory |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_addr | output | ADDR_W | Memory address bus |
| dq_out | output | DATA_W | Data toward the memory |
| dq_oe | output | 1 | Pad drive enable for dq_out |
| dq_in | input | DATA_W | Data from the memory |

## Verification
The checker watches, on every cycle, the relations that hold at any instant:
- the strobe encoding and the absence of bus contention;
- write enable falling only inside chip enable;
- the data driver rising only after write enable has fallen and releasing one cycle after it rises;
- address and write data staying stable while the bus is in use;
- req_ready dropping right after an acceptance;
- the read-valid pulse shape.

The exact window lengths — output-enable width, float gap before driving, write pulse width, data setup, post-read turnaround and cycle-time hold-off — are measured by the bench against its own rounding of the nanosecond values. The bench also shows that reads return the bytes written earlier, through a memory model that presents garbage until the access time has passed, and that a request offered while busy leaves memory untouched.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACC,
    ST_RD_FLT,
    ST_WR_SET,
    ST_WR_FLT,
    ST_WR_DAT,
    ST_WR_REC
  } seq_state_e;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
    logic drv;
  } strobe_t;

  // Interval in ns -> whole clock cycles, rounded up, at least one.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic strobe_t strobe_of(input seq_state_e s);
    strobe_t o;
    o = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};
    case (s)
      ST_RD_ACC: begin o.ce_n = 1'b0; o.oe_n = 1'b0; end
      ST_WR_SET: o.ce_n = 1'b0;
      ST_WR_FLT: begin o.ce_n = 1'b0; o.we_n = 1'b0; end
      ST_WR_DAT: begin o.ce_n = 1'b0; o.we_n = 1'b0; o.drv = 1'b1; end
      ST_WR_REC: begin o.ce_n = 1'b0; o.drv = 1'b1; end
      default:   ;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/ivl_timer.sv
module ivl_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctl_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned AA_C  = 2,
  parameter int unsigned OHZ_C = 1,
  parameter int unsigned AS_C  = 1,
  parameter int unsigned WHZ_C = 1,
  parameter int unsigned DAT_C = 2,
  parameter int unsigned RC_C  = 2,
  parameter int unsigned WC_C  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_wr,
  output logic ready,
  output logic capture,
  output logic ce_n,
  output logic we_n,
  output logic oe_n,
  output logic drv
);

  seq_state_e       state_q, state_d;
  strobe_t          strb_q;
  logic             ph_load, ph_zero, cyc_load, cyc_zero;
  logic [CNT_W-1:0] ph_val, cyc_val;

  ivl_timer #(.CNT_W(CNT_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val), .zero(ph_zero)
  );

  ivl_timer #(.CNT_W(CNT_W)) u_cycle (
    .clk(clk), .rst_n(rst_n), .load(cyc_load), .load_val(cyc_val), .zero(cyc_zero)
  );

  always_comb begin
    state_d  = state_q;
    ph_load  = 1'b0;
    ph_val   = '0;
    cyc_load = 1'b0;
    cyc_val  = '0;
    case (state_q)
      ST_IDLE: if (start) begin
        cyc_load = 1'b1;
        ph_load  = 1'b1;
        if (start_wr) begin
          cyc_val = CNT_W'(WC_C - 1);
          ph_val  = CNT_W'(AS_C - 1);
          state_d = ST_WR_SET;
        end else begin
          cyc_val = CNT_W'(RC_C - 1);
          ph_val  = CNT_W'(AA_C - 1);
          state_d = ST_RD_ACC;
        end
      end
      ST_RD_ACC: if (ph_zero) begin
        state_d = ST_RD_FLT;
        ph_load = 1'b1;
        ph_val  = CNT_W'(OHZ_C - 1);
      end
      ST_RD_FLT: if (ph_zero) state_d = ST_IDLE;
      ST_WR_SET: if (ph_zero) begin
        state_d = ST_WR_FLT;
        ph_load = 1'b1;
        ph_val  = CNT_W'(WHZ_C - 1);
      end
      ST_WR_FLT: if (ph_zero) begin
        state_d = ST_WR_DAT;
        ph_load = 1'b1;
        ph_val  = CNT_W'(DAT_C - 1);
      end
      ST_WR_DAT: if (ph_zero) state_d = ST_WR_REC;
      ST_WR_REC: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  // Strobes registered from the next state: glitch-free pins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      strb_q  <= strobe_of(ST_IDLE);
    end else begin
      state_q <= state_d;
      strb_q  <= strobe_of(state_d);
    end
  end

  assign ready   = (state_q == ST_IDLE) && cyc_zero;
  assign capture = (state_q == ST_RD_ACC) && ph_zero;
  assign ce_n    = strb_q.ce_n;
  assign we_n    = strb_q.we_n;
  assign oe_n    = strb_q.oe_n;
  assign drv     = strb_q.drv;

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 19,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned CLK_NS   = 10,
  parameter int unsigned T_RC_NS  = 20,
  parameter int unsigned T_AA_NS  = 20,
  parameter int unsigned T_WC_NS  = 20,
  parameter int unsigned T_WP_NS  = 15,
  parameter int unsigned T_DW_NS  = 12,
  parameter int unsigned T_AS_NS  = 0,
  parameter int unsigned T_WHZ_NS = 10,
  parameter int unsigned T_OHZ_NS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  input  logic [DATA_W-1:0] dq_in
);

  localparam int unsigned RC_C  = ns_to_cyc(T_RC_NS,  CLK_NS);
  localparam int unsigned AA_C  = ns_to_cyc(T_AA_NS,  CLK_NS);
  localparam int unsigned WC_C  = ns_to_cyc(T_WC_NS,  CLK_NS);
  localparam int unsigned WP_C  = ns_to_cyc(T_WP_NS,  CLK_NS);
  localparam int unsigned DW_C  = ns_to_cyc(T_DW_NS,  CLK_NS);
  localparam int unsigned AS_C  = ns_to_cyc(T_AS_NS,  CLK_NS);
  localparam int unsigned WHZ_C = ns_to_cyc(T_WHZ_NS, CLK_NS);
  localparam int unsigned OHZ_C = ns_to_cyc(T_OHZ_NS, CLK_NS);
  // Driven part of the pulse covers data setup and the rest of the pulse width.
  localparam int unsigned WP_REST = (WP_C > WHZ_C) ? (WP_C - WHZ_C) : 1;
  localparam int unsigned DAT_C   = (DW_C > WP_REST) ? DW_C : WP_REST;

  logic              rst_meta_q, rst_sync_q;
  logic              start, capture;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              rvalid_q;

  // Reset asserts at once, releases on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign start = req_valid && req_ready;

  sram_seq #(
    .CNT_W(CNT_W), .AA_C(AA_C), .OHZ_C(OHZ_C), .AS_C(AS_C),
    .WHZ_C(WHZ_C), .DAT_C(DAT_C), .RC_C(RC_C), .WC_C(WC_C)
  ) u_seq (
    .clk(clk), .rst_n(rst_sync_q), .start(start), .start_wr(req_write),
    .ready(req_ready), .capture(capture),
    .ce_n(sram_ce_n), .we_n(sram_we_n), .oe_n(sram_oe_n), .drv(dq_oe)
  );

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (start) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) rdata_q <= '0;
    else if (capture) rdata_q <= dq_in;
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) rvalid_q <= 1'b0;
    else             rvalid_q <= capture;
  end

  assign sram_addr = addr_q;
  assign dq_out    = wdata_q;
  assign rd_data   = rdata_q;
  assign rd_valid  = rvalid_q;

endmodule

// File: rtl/sram_strobe_chk.sv
module sram_strobe_chk #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rd_valid,
  input logic              sram_ce_n,
  input logic              sram_we_n,
  input logic              sram_oe_n,
  input logic [ADDR_W-1:0] sram_addr,
  input logic [DATA_W-1:0] dq_out,
  input logic              dq_oe
);

  assert_we_in_ce_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> !sram_ce_n);

  assert_no_contention_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> (sram_we_n && !dq_oe));

  assert_drive_after_we_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> (!sram_we_n && $past(!sram_we_n)));

  assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!sram_we_n || $past(!sram_we_n)));

  assert_addr_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));

  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_rdv_after_oe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!sram_oe_n));

  assert_rdv_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  assert_wdata_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && $past(dq_oe)) |-> $stable(dq_out));

endmodule

bind sram_strobe_ctrl sram_strobe_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_sram_strobe_ctrl.sv
`timescale 1ns/1ps
module sim_sram_strobe_ctrl;

  localparam int CLK = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rd_valid, sram_ce_n, sram_we_n, sram_oe_n, dq_oe;
  logic [7:0]  rd_data, dq_out;
  logic [18:0] sram_addr;
  logic [7:0]  dq_in = 8'hEE;

  int checks = 0, errors = 0, cyc = 0;
  bit mon_on = 0;

  always #2.5 clk = ~clk;

  sram_strobe_ctrl #(.CLK_NS(CLK)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .sram_ce_n(sram_ce_n),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .sram_addr(sram_addr),
    .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
  );

  function automatic int exp_cyc(int ns);
    int c = (ns + CLK - 1) / CLK;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int E_AA = 20, E_OHZ = 8, E_WP = 15, E_DW = 12, E_AS = 0, E_WHZ = 10, E_RC = 20, E_WC = 20;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  logic [7:0] model_mem  [int unsigned];
  logic [7:0] shadow_mem [int unsigned];

  function automatic logic [7:0] mget(int unsigned a);
    return model_mem.exists(a) ? model_mem[a] : 8'h00;
  endfunction
  function automatic logic [7:0] sget(int unsigned a);
    return shadow_mem.exists(a) ? shadow_mem[a] : 8'h00;
  endfunction

  // Monitor and memory model, sampled mid-cycle.
  logic        p_we = 1, p_oe = 1, p_ce = 1, p_drv = 0, p_rv = 0;
  logic [18:0] p_addr = '0;
  int we_run = 0, drv_run = 0, flt_run = 0, oe_run = 0, oe_cnt = 0;
  int ce_pre = 0, gap_cnt = 0, since = 0;
  bit we_seen = 0, gap_arm = 0, rel_pend = 0, since_arm = 0, acc_wr = 0;

  always @(negedge clk) if (mon_on) begin
    if (!sram_oe_n) check(sram_we_n && !dq_oe, "R2 oe low with we/drive", {sram_we_n, dq_oe}, 2);
    if (!sram_we_n) check(!sram_ce_n, "R2 we low outside ce", sram_ce_n, 0);
    if (!sram_ce_n && !p_ce) check(sram_addr == p_addr, "R6 addr moved in access", sram_addr, p_addr);
    if (rel_pend) begin
      check(!dq_oe, "R5 drive not released", dq_oe, 0);
      rel_pend = 0;
    end
    if (dq_oe && !p_drv) check(!sram_we_n && !p_we, "R5 drive before we low", {p_we, sram_we_n}, 0);
    if (!sram_ce_n && sram_we_n && !we_seen && sram_oe_n) ce_pre++;
    if (!sram_we_n && p_we) begin
      check(ce_pre >= exp_cyc(E_AS), "R6 ce lead before we", ce_pre, exp_cyc(E_AS));
      we_seen = 1;
    end
    if (!sram_we_n) begin
      we_run++;
      if (dq_oe) drv_run++;
      else if (drv_run == 0) flt_run++;
    end
    if (sram_we_n && !p_we) begin
      check(we_run >= exp_cyc(E_WP), "R4 we pulse width", we_run, exp_cyc(E_WP));
      check(flt_run == exp_cyc(E_WHZ), "R5 R9 float before drive", flt_run, exp_cyc(E_WHZ));
      check(drv_run >= exp_cyc(E_DW), "R5 data setup", drv_run, exp_cyc(E_DW));
      check(dq_oe, "R5 drive held after we rise", dq_oe, 1);
      model_mem[sram_addr] = dq_out;
      rel_pend = 1; we_run = 0; drv_run = 0; flt_run = 0;
    end
    if (sram_ce_n) begin ce_pre = 0; we_seen = 0; end
    if (!sram_oe_n) oe_run++;
    if (sram_oe_n && !p_oe) begin
      check(oe_run == exp_cyc(E_AA), "R3 R9 oe window", oe_run, exp_cyc(E_AA));
      oe_run = 0; gap_arm = 1; gap_cnt = 0;
    end
    if (gap_arm) begin
      if (sram_ce_n) gap_cnt++;
      else begin
        check(gap_cnt >= exp_cyc(E_OHZ), "R7 turnaround", gap_cnt, exp_cyc(E_OHZ));
        gap_arm = 0;
      end
    end
    if (rd_valid) check(!p_rv, "R3 rd_valid pulse width", p_rv, 0);
    if (since_arm) begin
      since++;
      if (since == 1) check(!req_ready, "R8 ready low after accept", req_ready, 0);
      if (req_ready) begin
        check(since >= exp_cyc(acc_wr ? E_WC : E_RC), "R8 cycle time", since, exp_cyc(acc_wr ? E_WC : E_RC));
        since_arm = 0;
      end
    end
    // Memory model: garbage until the access time has passed.
    if (!sram_ce_n && !sram_oe_n && sram_we_n) begin
      oe_cnt++;
      dq_in = (oe_cnt >= exp_cyc(E_AA)) ? mget(sram_addr) : 8'hEE;
    end else begin
      oe_cnt = 0;
      dq_in = 8'hEE;
    end
    p_we = sram_we_n; p_oe = sram_oe_n; p_ce = sram_ce_n; p_drv = dq_oe;
    p_rv = rd_valid; p_addr = sram_addr;
  end

  task automatic do_op(bit wr, logic [18:0] a, logic [7:0] d);
    int w = 0;
    @(negedge clk); #1;
    while (!req_ready) begin @(negedge clk); #1; end
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    acc_wr = wr; since = 0; since_arm = 1;
    @(negedge clk); #1;
    req_valid = 0;
    if (wr) shadow_mem[a] = d;
    else begin
      while (!rd_valid && w < 60) begin @(negedge clk); #1; w++; end
      check(rd_valid, "R3 rd_valid missing", rd_valid, 1);
      check(rd_data == sget(a), "R3 R10 read data", rd_data, sget(a));
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL R8 watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  logic [18:0] pool [16];

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    check(sram_ce_n && sram_we_n && sram_oe_n, "R1 strobes in reset", {sram_ce_n, sram_we_n, sram_oe_n}, 7);
    check(!dq_oe && !rd_valid, "R1 drive/valid in reset", {dq_oe, rd_valid}, 0);
    check(req_ready, "R1 ready in reset", req_ready, 1);
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    mon_on = 1;

    // Directed: extremes of address and data.
    do_op(1, 19'h7FFFF, 8'hA5);
    do_op(1, 19'h00000, 8'h5A);
    do_op(0, 19'h7FFFF, 8'h00);
    do_op(0, 19'h00000, 8'h00);
    do_op(1, 19'h40001, 8'hFF);
    do_op(0, 19'h40001, 8'h00);

    // R8: request offered while busy must be ignored.
    @(negedge clk); #1;
    while (!req_ready) begin @(negedge clk); #1; end
    req_valid = 1; req_write = 0; req_addr = 19'h7FFFF;
    @(negedge clk); #1;
    req_valid = 1; req_write = 1; req_addr = 19'h00000; req_wdata = 8'h11;
    check(!req_ready, "R8 busy during ignored request", req_ready, 0);
    @(negedge clk); #1;
    req_valid = 0;
    repeat (12) @(negedge clk);
    check(mget(0) == 8'h5A, "R8 ignored write reached memory", mget(0), 8'h5A);
    do_op(0, 19'h00000, 8'h00);

    // Back-to-back write then read at the same address.
    do_op(1, 19'h12345, 8'h3C);
    do_op(0, 19'h12345, 8'h00);

    // Random mix.
    foreach (pool[i]) pool[i] = 19'($urandom());
    for (int n = 0; n < 400; n++) begin
      logic [18:0] a;
      a = pool[$urandom_range(15)];
      do_op(1'($urandom_range(1)), a, 8'($urandom()));
    end

    repeat (10) @(negedge clk);
    check(sram_ce_n && !dq_oe && req_ready, "R1 R2 idle after traffic", {sram_ce_n, dq_oe, req_ready}, 5);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule